// File: doc/BRIEF.md
# Floating-Point Status and Exception Control Register

This block holds the status and control word that sits beside a floating-point datapath. Each time the datapath finishes an operation, it raises a completion strobe together with five raw exception indications. The block then rebuilds the per-operation cause field and folds the new causes into a sticky flag field. Any cause whose enable bit is set produces a one-cycle trap request that carries a fixed exception code. Software can also load the whole word. The load passes through a writable-bits mask, and the stored rounding-mode and denormal-control fields drive the datapath's truncation and flush-to-zero controls.

Each cycle is classified as one of four named events, and each event picks the next register value:

- `EV_IDLE` means no strobe. The register holds.
- `EV_LOAD` means a software load. It wins over everything else.
- `EV_OP` means an ordinary completion.
- `EV_APPROX` means completion of an approximate reciprocal-square-root operation. In that case the inexact indication is forced when no other indication is raised.

The transitions are:

- Any event to `EV_LOAD` whenever the load strobe is high.
- To `EV_OP` or `EV_APPROX` on a completion without a load.
- Back to `EV_IDLE` when neither strobe is present.

The register and the trap pulse update on the same clock edge.

Top module: `fpstat_ctl`

## Requirements
- R1: After reset the register reads zero, and `trap_req`, `trap_code`, `rnd_trunc` and `flush_den` are all zero.
- R2: On a completion, the cause field (bits 16:12) is cleared and then loaded from `exc_raw`. The mapping is `exc_raw[4]`=invalid to bit 16, `[3]`=divide-by-zero to bit 15, `[2]`=overflow to bit 14, `[1]`=underflow to bit 13, and `[0]`=inexact to bit 12.
- R3: On a completion, the new cause bits are ORed into the flag field (bits 6:2, in the same order, inexact at bit 2). A flag is never cleared by an operation. The enable field (bits 11:7), the rounding field (bits 1:0) and the denormal bit 18 are left unchanged.
- R4: One cycle after a completion whose new causes share a set bit with the enable field, `trap_req` is high for exactly that cycle and `trap_code` reads 0x120. Otherwise `trap_req` is low and `trap_code` reads zero.
- R5: For an approximate operation (`op_approx` high with `op_done`) whose `exc_raw` is all zero, the inexact cause is forced. If any raw indication is set, the raw value is used unchanged.
- R6: A software load stores `ld_data & 0x0005FFFF`. Bits 17 and 31:19 always read zero.
- R7: A software load never raises `trap_req`. When a load and a completion occur in the same cycle, the load value is stored and the completion's indications are discarded.
- R8: `rnd_trunc` is high exactly when the stored rounding field equals 01 (round to zero). The values 00, 10 and 11 all select round-to-nearest-even (`rnd_trunc` low).
- R9: `flush_den` follows stored bit 18.
- R10: In a cycle with neither strobe, the register holds its value and no trap is issued the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Value to load before masking |
| op_done | input | 1 | Floating-point operation completion strobe |
| op_approx | input | 1 | Completing operation is the approximate reciprocal square root |
| exc_raw | input | 5 | Raw indications {invalid, div-by-zero, overflow, underflow, inexact} |
| csr_q | output | 32 | Current register contents |
| trap_req | output | 1 | One-cycle trap request |
| trap_code | output | 12 | Exception code while `trap_req` is high, else zero |
| rnd_trunc | output | 1 | Datapath rounding select: 1 = truncate, 0 = nearest-even |
| flush_den | output | 1 | Datapath denormal flush-to-zero enable |

## Verification
The hardest situations to reach are the ones where two conditions meet in one cycle. One is a load colliding with a completion, whose indications would otherwise trap. The other is an approximate operation with no raw indication, so that the forced inexact cause alone hits the only enabled trap. The stimulus first loads chosen enables, stale flags and stale causes through the software path. It then fires every one of the 32 raw patterns against every one of the 32 enable masks, and repeats the sweep for the approximate operation. Collisions are driven with every enable set and every raw indication high, so that any leak of the operation shows up as a trap or as changed causes.

// File: rtl/fpstat_pkg.sv
`timescale 1ns/1ps
package fpstat_pkg;

    // register geometry
    localparam int unsigned CSR_W   = 32;
    localparam int unsigned EXC_N   = 5;
    localparam int unsigned RM_W    = 2;
    localparam int unsigned RM_LSB  = 0;
    localparam int unsigned FLG_LSB = RM_LSB + RM_W;
    localparam int unsigned ENA_LSB = FLG_LSB + EXC_N;
    localparam int unsigned CAU_LSB = ENA_LSB + EXC_N;
    localparam int unsigned DNM_BIT = CAU_LSB + EXC_N + 1;

    // raw indication / field bit order
    localparam int unsigned EXC_I = 0;
    localparam int unsigned EXC_U = 1;
    localparam int unsigned EXC_O = 2;
    localparam int unsigned EXC_Z = 3;
    localparam int unsigned EXC_V = 4;

    localparam logic [RM_W-1:0] RM_TRUNC = 2'b01;

    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,
        EV_LOAD   = 2'd1,
        EV_OP     = 2'd2,
        EV_APPROX = 2'd3
    } fpstat_ev_e;

    function automatic logic [CSR_W-1:0] writable_mask();
        logic [CSR_W-1:0] m;
        m = '0;
        for (int b = 0; b < int'(RM_W); b++)  m[RM_LSB + b]  = 1'b1;
        for (int b = 0; b < int'(EXC_N); b++) begin
            m[FLG_LSB + b] = 1'b1;
            m[ENA_LSB + b] = 1'b1;
            m[CAU_LSB + b] = 1'b1;
        end
        m[DNM_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [CSR_W-1:0] WMASK = writable_mask();

endpackage

// File: rtl/fpstat_evsel.sv
`timescale 1ns/1ps
module fpstat_evsel
    import fpstat_pkg::*;
(
    input  logic       ld_en,
    input  logic       op_done,
    input  logic       op_approx,
    output fpstat_ev_e ev
);

    // software load outranks an operation completing in the same cycle
    always_comb begin
        if (ld_en)
            ev = EV_LOAD;
        else if (op_done)
            ev = op_approx ? EV_APPROX : EV_OP;
        else
            ev = EV_IDLE;
    end

endmodule

// File: rtl/fpstat_cause.sv
`timescale 1ns/1ps
module fpstat_cause #(
    parameter int unsigned N      = 5,
    parameter int unsigned INEXACT = 0
) (
    input  logic [N-1:0] raw,
    input  logic         approx,
    output logic [N-1:0] cause
);

    logic none_raised;
    assign none_raised = (raw == '0);

    for (genvar i = 0; i < int'(N); i++) begin : g_bit
        if (i == int'(INEXACT)) begin : g_inx
            assign cause[i] = raw[i] | (approx & none_raised);
        end else begin : g_pass
            assign cause[i] = raw[i];
        end
    end

endmodule

// File: rtl/fpstat_trap.sv
`timescale 1ns/1ps
module fpstat_trap #(
    parameter int unsigned N = 5
) (
    input  logic         fire,
    input  logic [N-1:0] cause,
    input  logic [N-1:0] enable,
    output logic         hit
);

    logic [N-1:0] armed;
    assign armed = cause & enable;
    assign hit   = fire & (|armed);

endmodule

// File: rtl/fpstat_ctl.sv
`timescale 1ns/1ps
module fpstat_ctl
    import fpstat_pkg::*;
#(
    parameter int unsigned      CODE_W    = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 'h120
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [CSR_W-1:0]   ld_data,
    input  logic               op_done,
    input  logic               op_approx,
    input  logic [EXC_N-1:0]   exc_raw,
    output logic [CSR_W-1:0]   csr_q,
    output logic               trap_req,
    output logic [CODE_W-1:0]  trap_code,
    output logic               rnd_trunc,
    output logic               flush_den
);

    fpstat_ev_e        ev;
    logic [CSR_W-1:0]  csr_r;
    logic [CSR_W-1:0]  csr_nx;
    logic [EXC_N-1:0]  cause_eff;
    logic [EXC_N-1:0]  enables;
    logic [EXC_N-1:0]  flags;
    logic              is_op;
    logic              trap_hit;
    logic              trap_r;

    fpstat_evsel u_evsel (
        .ld_en     (ld_en),
        .op_done   (op_done),
        .op_approx (op_approx),
        .ev        (ev)
    );

    fpstat_cause #(.N(EXC_N), .INEXACT(EXC_I)) u_cause (
        .raw    (exc_raw),
        .approx (ev == EV_APPROX),
        .cause  (cause_eff)
    );

    assign enables = csr_r[ENA_LSB +: EXC_N];
    assign flags   = csr_r[FLG_LSB +: EXC_N];
    assign is_op   = (ev == EV_OP) || (ev == EV_APPROX);

    fpstat_trap #(.N(EXC_N)) u_trap (
        .fire   (is_op),
        .cause  (cause_eff),
        .enable (enables),
        .hit    (trap_hit)
    );

    // next-value selection per event
    always_comb begin
        csr_nx = csr_r;
        unique case (ev)
            EV_IDLE:   csr_nx = csr_r;
            EV_LOAD:   csr_nx = ld_data & WMASK;
            EV_OP,
            EV_APPROX: begin
                csr_nx[CAU_LSB +: EXC_N] = cause_eff;
                csr_nx[FLG_LSB +: EXC_N] = flags | cause_eff;
            end
            default:   csr_nx = csr_r;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_r  <= '0;
            trap_r <= 1'b0;
        end else begin
            csr_r  <= csr_nx;
            trap_r <= trap_hit;
        end
    end

    // outputs
    always_comb begin
        csr_q     = csr_r;
        trap_req  = trap_r;
        trap_code = trap_r ? TRAP_CODE : '0;
        rnd_trunc = (csr_r[RM_LSB +: RM_W] == RM_TRUNC);
        flush_den = csr_r[DNM_BIT];
    end

endmodule

// File: rtl/fpstat_ctl_chk.sv
`timescale 1ns/1ps
module fpstat_ctl_chk
    import fpstat_pkg::*;
#(
    parameter int unsigned      CODE_W    = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 'h120
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [CSR_W-1:0]  ld_data,
    input logic              op_done,
    input logic              op_approx,
    input logic [EXC_N-1:0]  exc_raw,
    input logic [CSR_W-1:0]  csr_q,
    input logic              trap_req,
    input logic [CODE_W-1:0] trap_code
);

    localparam logic [EXC_N-1:0] ONLY_INEXACT = EXC_N'(1) << EXC_I;

    // R6
    load_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> csr_q == ($past(ld_data) & WMASK));

    // R7
    load_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !trap_req);

    // R2
    cause_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !ld_en && exc_raw != '0) |=> csr_q[CAU_LSB +: EXC_N] == $past(exc_raw));

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> (csr_q[FLG_LSB +: EXC_N] & $past(csr_q[FLG_LSB +: EXC_N]))
                   == $past(csr_q[FLG_LSB +: EXC_N]));

    // R3
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> csr_q[ENA_LSB +: EXC_N] == $past(csr_q[ENA_LSB +: EXC_N]));

    // R4
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> |(csr_q[CAU_LSB +: EXC_N] & csr_q[ENA_LSB +: EXC_N]));

    // R4
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_code == TRAP_CODE);

    // R5
    approx_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_approx && !ld_en && exc_raw == '0)
        |=> csr_q[CAU_LSB +: EXC_N] == ONLY_INEXACT);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !op_done) |=> ($stable(csr_q) && !trap_req));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_q & ~WMASK) == '0);

endmodule

bind fpstat_ctl fpstat_ctl_chk #(.CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_data   (ld_data),
    .op_done   (op_done),
    .op_approx (op_approx),
    .exc_raw   (exc_raw),
    .csr_q     (csr_q),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/fpstat_ctl_tb_top.sv
`timescale 1ns/1ps
module fpstat_ctl_tb_top;

    localparam logic [31:0] MASK = 32'h0005_FFFF;
    localparam logic [11:0] CODE = 12'h120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_data = '0;
    logic        op_done = 1'b0;
    logic        op_approx = 1'b0;
    logic [4:0]  exc_raw = '0;
    logic [31:0] csr_q;
    logic        trap_req;
    logic [11:0] trap_code;
    logic        rnd_trunc;
    logic        flush_den;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_csr;
    logic        m_trap;

    always #4 clk = ~clk;

    fpstat_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
        .op_done(op_done), .op_approx(op_approx), .exc_raw(exc_raw),
        .csr_q(csr_q), .trap_req(trap_req), .trap_code(trap_code),
        .rnd_trunc(rnd_trunc), .flush_den(flush_den)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk({tag, " csr"}, csr_q, m_csr);
        chk({tag, " trap"}, {31'd0, trap_req}, {31'd0, m_trap});
        chk({tag, " code"}, {20'd0, trap_code}, m_trap ? {20'd0, CODE} : 32'd0);
    endtask

    task automatic do_load(input logic [31:0] d);
        ld_en = 1'b1; ld_data = d;
        step();
        ld_en = 1'b0;
        m_csr = d & MASK; m_trap = 1'b0;
        check_all("R6 load");
    endtask

    task automatic do_op(input logic [4:0] raw, input logic apx, input string tag);
        logic [4:0] eff;
        op_done = 1'b1; op_approx = apx; exc_raw = raw;
        step();
        op_done = 1'b0; op_approx = 1'b0; exc_raw = '0;
        eff = (apx && raw == 5'd0) ? 5'b00001 : raw;
        m_csr[16:12] = eff;
        m_csr[6:2]   = m_csr[6:2] | eff;
        m_trap = |(eff & m_csr[11:7]);
        chk({tag, " R2 cause"}, {27'd0, csr_q[16:12]}, {27'd0, eff});
        chk({tag, " R3 flags"}, {27'd0, csr_q[6:2]}, {27'd0, m_csr[6:2]});
        chk({tag, " R4 trap"}, {31'd0, trap_req}, {31'd0, m_trap});
        check_all({tag, " R3 rest"});
    endtask

    task automatic do_idle();
        step();
        m_trap = 1'b0;
        check_all("R10 idle");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_csr = '0; m_trap = 1'b0;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 csr", csr_q, 32'd0);
        chk("R1 outs", {29'd0, trap_req, rnd_trunc, flush_den}, 32'd0);
        chk("R1 code", {20'd0, trap_code}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // full sweep: every enable mask against every raw pattern
        for (int e = 0; e < 32; e++) begin
            for (int x = 0; x < 32; x++) begin
                logic [31:0] d;
                d = (32'(e) << 7) | (32'((x * 7) & 31) << 2) | 32'(x & 3)
                  | (32'(e ^ 21) << 12) | (32'(x & 1) << 18) | 32'hFFF8_0000;
                do_load(d);
                do_op(5'(x), 1'b0, "sweep");
                do_idle();
            end
        end

        // R5 approximate op against each raw pattern, inexact-only enable
        for (int x = 0; x < 32; x++) begin
            do_load(32'h0000_0080 | (32'(x) << 12));
            do_op(5'(x), 1'b1, "R5 approx");
            do_idle();
        end
        // R5 approximate with all enables and no raw indication
        do_load(32'h0000_0F80);
        do_op(5'd0, 1'b1, "R5 approx all-en");

        // R3 accumulation without reload
        do_load(32'd0);
        for (int k = 0; k < 5; k++) begin
            do_op(5'(1 << k), 1'b0, "R3 accum");
        end
        do_op(5'd0, 1'b0, "R3 accum zero");
        chk("R3 flags all set", {27'd0, csr_q[6:2]}, 32'h1F);

        // R7 collision: load wins, no trap
        do_load(32'h0000_0F80);
        ld_en = 1'b1; ld_data = 32'h0001_FF80;
        op_done = 1'b1; exc_raw = 5'h1F;
        step();
        ld_en = 1'b0; op_done = 1'b0; exc_raw = '0;
        m_csr = 32'h0001_FF80; m_trap = 1'b0;
        check_all("R7 collide");
        chk("R7 no trap", {31'd0, trap_req}, 32'd0);
        do_idle();

        // R6 reserved bits
        do_load(32'hFFFF_FFFF);
        chk("R6 reserved", csr_q & ~MASK, 32'd0);

        // R8 / R9 rounding and denormal decode
        for (int rm = 0; rm < 4; rm++) begin
            for (int dn = 0; dn < 2; dn++) begin
                do_load(32'(rm) | (32'(dn) << 18));
                chk("R8 rnd_trunc", {31'd0, rnd_trunc}, (rm == 1) ? 32'd1 : 32'd0);
                chk("R9 flush_den", {31'd0, flush_den}, 32'(dn));
                do_op(5'h1F, 1'b0, "R9 op keeps mode");
                chk("R8 rnd after op", {31'd0, rnd_trunc}, (rm == 1) ? 32'd1 : 32'd0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule